// File: doc/BRIEF.md
# Word Boundary Checking Deserializer

This block turns a single-wire serial bit stream, sampled once per bit clock, back into parallel data words. Each frame on the wire is 25 bits long: one start bit at 0, a 22-bit payload sent least significant bit first, and a pair of trailer bits. Both trailer bits must carry the inverse of the payload's top bit, which guarantees at least one level change per frame. The block uses this rule to find frame alignment. Once locked, it checks the same rule on every frame.

When a locked frame breaks the trailer rule, the block raises a one-cycle error pulse. It then goes into a powered-down state in which it drives a request to pull the serial link high. The far end is expected to see the raised link, stop sending and go quiet. When the block has seen the line hold at 0 for a full quiet window, it drops the request and starts hunting for alignment again.

A global enable input turns off the trailer checking and the link handshake while it is low. A saturating counter keeps a running total of trailer errors.

Top module: `wbc_deser`

## Requirements
- R1: The first bit after the start bit becomes `word_out[0]` and the 22nd becomes `word_out[21]`.
- R2: In the hunt state, alignment is taken from a 0 bit whose three predecessors are b, ~b, ~b. Lock is declared after the next two frames both pass the trailer rule. No strobe is issued for those two frames or for anything before them. The first strobe belongs to the frame that follows them.
- R3: `word_stb` is a one-cycle pulse in the cycle after the second trailer bit of a good locked frame, and `word_out` takes the new word in that same cycle. Between strobes, `word_out` keeps its value.
- R4: When locked, a trailer bit that is not the inverse of payload bit 21 is a boundary error. It gives a single `frame_err` pulse in the cycle after that bit, and the frame produces no strobe.
- R5: `pullup_req` rises in the same cycle as `frame_err`. It falls in the cycle after the 25th consecutive 0 on `ser_in` has been sampled. Any 1 restarts that count.
- R6: While `pullup_req` is high, no strobe is issued. After it falls, the block realigns under the rule of R2 and then delivers words again.
- R7: While `link_en` is 0, no trailer check, error, pull-up request or strobe occurs, and `word_out` holds. When `link_en` returns to 1, alignment starts afresh under R2.
- R8: `err_count` goes up by one on each `frame_err` pulse, stays at its all-ones value (15 by default) once it gets there, and is cleared only by reset.
- R9: During and directly after reset, `word_out`, `word_stb`, `frame_err`, `pullup_req` and `err_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_en | input | 1 | 1 for normal operation; 0 turns off checking and handshake |
| ser_in | input | 1 | Recovered serial data bit |
| word_out | output | DATA_W | Last delivered parallel word |
| word_stb | output | 1 | One-cycle pulse marking a new `word_out` |
| frame_err | output | 1 | One-cycle pulse on a boundary error |
| pullup_req | output | 1 | Request to pull the serial link high (receiver powered down) |
| err_count | output | CNT_W | Saturating count of boundary errors |

## Verification
A wrong frame index or a wrong shift-register fill shows up at the ports within one frame (25 bit clocks). It appears as a delivered word whose bits are rotated or mixed up, or as a missing or extra strobe. An alignment state that is stuck or left too early changes how many strobes come out before the first delivered word. An off-by-one in the quiet timer moves the fall of `pullup_req` by exactly one cycle, which the bench checks on both sides of the boundary. Errors in the counter show up as an `err_count` step with no matching `frame_err` pulse, or as a count that wraps past its top value.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_SYNC = 2'd1,
        RX_LOCK = 2'd2,
        RX_PULL = 2'd3
    } rx_state_e;

    // A trailer bit is correct when it is the inverse of the top payload bit.
    function automatic logic trailer_ok(input logic top_bit, input logic trailer_bit);
        return trailer_bit == ~top_bit;
    endfunction

endpackage

// File: rtl/wbc_pattern_det.sv
module wbc_pattern_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_in,
    output logic hit
);
    localparam int HIST_W = 3;

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } pd_t;

    pd_t pd_d, pd_q;

    always_comb begin
        pd_d      = pd_q;
        pd_d.hist = {pd_q.hist[HIST_W-2:0], ser_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pd_q <= '0;
        else        pd_q <= pd_d;
    end

    // hist[2] = payload top bit, hist[1:0] = trailer pair, ser_in = start bit
    assign hit = !ser_in
               && (pd_q.hist[2] != pd_q.hist[1])
               && (pd_q.hist[1] == pd_q.hist[0]);

endmodule

// File: rtl/wbc_quiet_timer.sv
module wbc_quiet_timer #(
    parameter int QUIET_LEN = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ser_in,
    output logic expired
);
    localparam int QW = $clog2(QUIET_LEN + 1);
    localparam logic [QW-1:0] Q_LAST = QW'(QUIET_LEN - 1);

    typedef struct packed {
        logic [QW-1:0] run;
    } qt_t;

    qt_t qt_d, qt_q;

    always_comb begin
        qt_d = qt_q;
        if (!arm || ser_in) begin
            qt_d.run = '0;
        end else if (qt_q.run != Q_LAST) begin
            qt_d.run = qt_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qt_q <= '0;
        else        qt_q <= qt_d;
    end

    assign expired = arm && !ser_in && (qt_q.run == Q_LAST);

endmodule

// File: rtl/wbc_sat_counter.sv
module wbc_sat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] C_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } sc_t;

    sc_t sc_d, sc_q;

    always_comb begin
        sc_d = sc_q;
        if (inc && (sc_q.cnt != C_MAX)) begin
            sc_d.cnt = sc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign value = sc_q.cnt;

endmodule

// File: rtl/wbc_deser.sv
module wbc_deser
    import wbc_pkg::*;
#(
    parameter int DATA_W      = 22,
    parameter int QUIET_LEN   = 25,
    parameter int LOCK_FRAMES = 2,
    parameter int CNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic              ser_in,
    output logic [DATA_W-1:0] word_out,
    output logic              word_stb,
    output logic              frame_err,
    output logic              pullup_req,
    output logic [CNT_W-1:0]  err_count
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int LOCK_W  = $clog2(LOCK_FRAMES) + 1;

    localparam logic [IDX_W-1:0]  IDX_DATA0 = IDX_W'(1);
    localparam logic [IDX_W-1:0]  IDX_DATAN = IDX_W'(DATA_W);
    localparam logic [IDX_W-1:0]  IDX_BND0  = IDX_W'(DATA_W + 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(DATA_W + 2);
    localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(LOCK_FRAMES - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic [LOCK_W-1:0] good;
        logic [DATA_W-1:0] word;
        logic              stb;
        logic              err;
    } rx_t;

    rx_t  rx_d, rx_q;
    logic hunt_hit;
    logic quiet_done;
    logic err_hit;
    logic in_data, at_trailer, trailer_bad;

    wbc_pattern_det u_pat (
        .clk    (clk),
        .rst_n  (rst_n),
        .ser_in (ser_in),
        .hit    (hunt_hit)
    );

    wbc_quiet_timer #(.QUIET_LEN(QUIET_LEN)) u_quiet (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (rx_q.st == RX_PULL),
        .ser_in  (ser_in),
        .expired (quiet_done)
    );

    wbc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (err_hit),
        .value (err_count)
    );

    always_comb begin
        in_data     = (rx_q.idx >= IDX_DATA0) && (rx_q.idx <= IDX_DATAN);
        at_trailer  = (rx_q.idx == IDX_BND0) || (rx_q.idx == IDX_LAST);
        trailer_bad = at_trailer && !trailer_ok(rx_q.shreg[DATA_W-1], ser_in);
    end

    always_comb begin
        rx_d     = rx_q;
        rx_d.stb = 1'b0;
        rx_d.err = 1'b0;
        err_hit  = 1'b0;

        if (!link_en) begin
            rx_d.st   = RX_HUNT;
            rx_d.idx  = '0;
            rx_d.good = '0;
        end else begin
            unique case (rx_q.st)
                RX_HUNT: begin
                    if (hunt_hit) begin
                        rx_d.st   = RX_SYNC;
                        rx_d.idx  = IDX_DATA0;
                        rx_d.good = '0;
                    end
                end
                RX_SYNC, RX_LOCK: begin
                    rx_d.idx = (rx_q.idx == IDX_LAST) ? '0 : rx_q.idx + 1'b1;
                    if (in_data) begin
                        rx_d.shreg = {ser_in, rx_q.shreg[DATA_W-1:1]};
                    end
                    if (trailer_bad) begin
                        if (rx_q.st == RX_LOCK) begin
                            rx_d.st  = RX_PULL;
                            rx_d.err = 1'b1;
                            err_hit  = 1'b1;
                        end else begin
                            rx_d.st = RX_HUNT;
                        end
                        rx_d.idx  = '0;
                        rx_d.good = '0;
                    end else if (rx_q.idx == IDX_LAST) begin
                        if (rx_q.st == RX_LOCK) begin
                            rx_d.word = rx_q.shreg;
                            rx_d.stb  = 1'b1;
                        end else if (rx_q.good == LOCK_LAST) begin
                            rx_d.st = RX_LOCK;
                        end else begin
                            rx_d.good = rx_q.good + 1'b1;
                        end
                    end
                end
                RX_PULL: begin
                    if (quiet_done) begin
                        rx_d.st = RX_HUNT;
                    end
                end
                default: rx_d.st = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q    <= '0;
            rx_q.st <= RX_HUNT;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign word_out   = rx_q.word;
    assign word_stb   = rx_q.stb;
    assign frame_err  = rx_q.err;
    assign pullup_req = (rx_q.st == RX_PULL);

endmodule

// File: rtl/wbc_deser_chk.sv
module wbc_deser_chk #(
    parameter int DATA_W = 22,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              link_en,
    input logic              ser_in,
    input logic [DATA_W-1:0] word_out,
    input logic              word_stb,
    input logic              frame_err,
    input logic              pullup_req,
    input logic [CNT_W-1:0]  err_count
);
    localparam logic [CNT_W-1:0] C_MAX = '1;

    // R3: the word changes only together with a strobe
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb |-> $stable(word_out));

    // R4 / R5: an error always comes with the pull-up request
    p_err_to_pullup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> pullup_req);

    // R5: the request is released only after a quiet bit, or by the enable
    p_quiet_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pullup_req) |-> (!$past(ser_in) || !$past(link_en)));

    // R6: no strobe while powered down
    p_no_stb_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> !pullup_req);

    // R7: a disabled link produces no error, request or strobe
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (!frame_err && !pullup_req && !word_stb));

    // R8: the count moves only on an error
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_err |-> $stable(err_count));

    // R8: one step per error until saturation
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && $past(err_count) != C_MAX)
            |-> ((err_count - $past(err_count)) == CNT_W'(1)));

    // R8: saturation holds the top value
    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_count) == C_MAX) |-> (err_count == C_MAX));

endmodule

bind wbc_deser wbc_deser_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_en    (link_en),
    .ser_in     (ser_in),
    .word_out   (word_out),
    .word_stb   (word_stb),
    .frame_err  (frame_err),
    .pullup_req (pullup_req),
    .err_count  (err_count)
);

// File: tb/wbc_deser_bench.sv
module wbc_deser_bench;
    localparam int CLK_P  = 10;
    localparam int N_VEC  = 8;

    // {stimulus payload, expected delivered word}
    localparam logic [43:0] VEC [N_VEC] = '{
        {22'h3FFFFF, 22'h3FFFFF},
        {22'h000000, 22'h000000},
        {22'h2AAAAA, 22'h2AAAAA},
        {22'h155555, 22'h155555},
        {22'h200000, 22'h200000},
        {22'h000001, 22'h000001},
        {22'h123456, 22'h123456},
        {22'h3ABCDE, 22'h3ABCDE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_en = 1'b1;
    logic        ser_in = 1'b0;
    logic [21:0] word_out;
    logic        word_stb;
    logic        frame_err;
    logic        pullup_req;
    logic [3:0]  err_count;

    int n_chk = 0;
    int n_bad = 0;
    int stb_cnt = 0;
    int err_seen = 0;
    logic [21:0] cap [0:63];

    always #(CLK_P/2) clk = ~clk;

    wbc_deser u_wbc_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_en    (link_en),
        .ser_in     (ser_in),
        .word_out   (word_out),
        .word_stb   (word_stb),
        .frame_err  (frame_err),
        .pullup_req (pullup_req),
        .err_count  (err_count)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (word_stb) begin
                if (stb_cnt < 64) cap[stb_cnt] = word_out;
                stb_cnt = stb_cnt + 1;
            end
            if (frame_err) err_seen = err_seen + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_in = b;
    endtask

    task automatic send_body(input logic [21:0] d, input logic bad);
        for (int i = 0; i < 22; i++) send_bit(d[i]);
        send_bit(bad ? d[21] : ~d[21]);
        send_bit(bad ? d[21] : ~d[21]);
    endtask

    // Frames A, B, C of zero payload: alignment at B, lock after C.
    // Leaves the start bit of the next frame placed on the line.
    task automatic acquire();
        send_body(22'h0, 1'b0);
        send_bit(1'b0);
        send_body(22'h0, 1'b0);
        send_bit(1'b0);
        send_body(22'h0, 1'b0);
        send_bit(1'b0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R9 word_out", 32'(word_out), 32'h0);
        chk("R9 word_stb", 32'(word_stb), 32'h0);
        chk("R9 frame_err", 32'(frame_err), 32'h0);
        chk("R9 pullup_req", 32'(pullup_req), 32'h0);
        chk("R9 err_count", 32'(err_count), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9 after release", 32'({word_stb, pullup_req, err_count}), 32'h0);

        // R2: acquisition, then the vector table while locked
        repeat (3) send_bit(1'b0);
        send_bit(1'b0);
        acquire();
        for (int v = 0; v < N_VEC; v++) begin
            send_body(VEC[v][43:22], 1'b0);
            send_bit(1'b0);
        end
        #1;
        chk("R2 strobe count", 32'(stb_cnt), 32'(N_VEC));
        for (int v = 0; v < N_VEC; v++) begin
            chk("R1 R3 delivered word", 32'(cap[v]), 32'(VEC[v][21:0]));
        end

        // R4: boundary error while locked
        send_body(22'h0, 1'b1);
        repeat (5) send_bit(1'b1);
        #1;
        chk("R4 single error pulse", 32'(err_seen), 32'd1);
        chk("R4 no strobe for bad frame", 32'(stb_cnt), 32'(N_VEC));
        chk("R8 count after error", 32'(err_count), 32'd1);
        chk("R5 pullup raised", 32'(pullup_req), 32'd1);

        // R6: frames during pull-up are not delivered
        send_bit(1'b0);
        send_body(22'h3FFFFF, 1'b0);
        repeat (5) send_bit(1'b1);
        #1;
        chk("R6 no strobe in pullup", 32'(stb_cnt), 32'(N_VEC));
        chk("R6 pullup held by ones", 32'(pullup_req), 32'd1);

        // R5: exact quiet window
        repeat (25) send_bit(1'b0);
        #1;
        chk("R5 pullup after 24 zeros", 32'(pullup_req), 32'd1);
        send_bit(1'b0);
        #1;
        chk("R5 pullup after 25 zeros", 32'(pullup_req), 32'd0);

        // R6: realignment and delivery after release
        send_bit(1'b0);
        acquire();
        send_body(22'h2F0F0F, 1'b0);
        send_bit(1'b0);
        #1;
        chk("R6 strobe after recovery", 32'(stb_cnt), 32'(N_VEC + 1));
        chk("R6 recovered word", 32'(cap[N_VEC]), 32'h2F0F0F);

        // R7: checking off while link_en is low
        link_en = 1'b0;
        send_body(22'h0, 1'b1);
        send_bit(1'b0);
        #1;
        chk("R7 no error when off", 32'(err_seen), 32'd1);
        chk("R7 no pullup when off", 32'(pullup_req), 32'd0);
        chk("R7 count unchanged", 32'(err_count), 32'd1);
        chk("R7 no strobe when off", 32'(stb_cnt), 32'(N_VEC + 1));
        chk("R7 word held", 32'(word_out), 32'h2F0F0F);
        link_en = 1'b1;
        acquire();
        send_body(22'h0C3A5F, 1'b0);
        send_bit(1'b0);
        #1;
        chk("R7 rearm strobe", 32'(stb_cnt), 32'(N_VEC + 2));
        chk("R7 rearm word", 32'(cap[N_VEC + 1]), 32'h0C3A5F);

        // R8: saturation of the error counter
        for (int e = 0; e < 16; e++) begin
            send_body(22'h0, 1'b1);
            repeat (30) send_bit(1'b0);
            acquire();
            if (e == 13) begin
                #1;
                chk("R8 count reaches max", 32'(err_count), 32'd15);
            end
        end
        #1;
        chk("R8 count saturated", 32'(err_count), 32'd15);
        chk("R8 all errors pulsed", 32'(err_seen), 32'd17);

        // R8: cleared by reset only
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R8 cleared by reset", 32'(err_count), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule